// File: doc/BRIEF.md
# Line-Size Configurable Miss Refill Controller

This controller services cache misses for a line array whose physical line is four 32-bit words (16 bytes). Software chooses a logical line size of 16, 32 or 64 bytes through a small size register. On a miss, the controller fetches the whole aligned logical block, one word per memory transfer in ascending address order. It writes each word into the line array and marks each physical line valid once all of its words are in place.

The processor-side stall logic sees a `stall` level while a refill is running and a one-cycle `done` pulse when it ends. A change of the size code arriving during a refill is held back and applied only once the refill has completed, so a block is always fetched with a single size. The memory side is a single-outstanding request/response handshake: the request and its address stay asserted until the response strobe arrives.

Top module: `lnfill_ctrl`

## Requirements
- R1: After reset `stall`, `done`, `mem_req`, `arr_we` and `arr_vld_set` are low and `cfg_cur` reads 0.
- R2: Size code 0 selects 4 words (16 bytes), 1 selects 8 words (32 bytes), 2 selects 16 words (64 bytes); a write of code 3 is ignored and `cfg_cur` keeps its value.
- R3: A refill fetches exactly 4<<code words, starting at `miss_addr` with its low 4+code bits cleared, each request address 4 above the previous one.
- R4: `mem_req` and `mem_addr` hold steady until a cycle with `mem_rsp_valid` high; only one request is outstanding at a time.
- R5: In each response cycle `arr_we` is high, `arr_wdata` equals `mem_rdata`, `arr_line` equals address bits [9:4] and `arr_word_sel` equals address bits [3:2] of the word being written.
- R6: `arr_vld_set` pulses for one cycle, in the cycle after word 3 of a physical line is written, with `arr_line` naming that line; this happens once per physical line.
- R7: Between consecutive physical lines of one refill there is exactly one cycle with `stall` high and `mem_req` low; a 16-byte refill has no such cycle.
- R8: `done` is a one-cycle pulse in the cycle after the final word is written; `stall` is high from the cycle after a miss is accepted up to that pulse, and low during it.
- R9: `miss_valid` is acted on only when the controller is idle; a miss presented during a refill has no effect.
- R10: A legal size write made during a refill does not change `cfg_cur` until the cycle after `done`; of several such writes the last one wins.
- R11: A miss accepted in the same cycle as an idle size write uses the previous size; the new size is in effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Size register write strobe |
| cfg_code | input | 2 | Size code to write (0, 1 or 2) |
| cfg_cur | output | 2 | Size code currently in effect |
| miss_valid | input | 1 | Miss request, one cycle |
| miss_addr | input | 32 | Byte address of the missing access |
| stall | output | 1 | Refill in progress, processor must wait |
| done | output | 1 | One-cycle refill completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_rsp_valid | input | 1 | Memory response strobe, consumes the request |
| mem_rdata | input | 32 | Memory read data |
| arr_we | output | 1 | Line array word write enable |
| arr_vld_set | output | 1 | Set the valid bit of `arr_line` |
| arr_line | output | 6 | Physical line index for write or valid set |
| arr_word_sel | output | 2 | Word within the physical line |
| arr_wdata | output | 32 | Word to write |

## Verification
A wrong fetch counter or start alignment shows at once on `mem_addr` in the first request of a refill, and at the end as a wrong number of array writes before `done`. A lost or extra line boundary shows as a valid-set pulse on the wrong line, or as a missing or surplus gap cycle, within one physical line of the fault. A size register that escapes its hold-off shows in `cfg_cur` in the cycle it changes. It also shows in the length of the next refill. The bench compares every output against its model on every clock, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/lnfill_pkg.sv
`timescale 1ns/1ps
package lnfill_pkg;
   typedef enum logic [1:0] {
      LF_IDLE  = 2'd0,
      LF_FETCH = 2'd1,
      LF_SEAL  = 2'd2
   } lf_state_e;
endpackage

// File: rtl/lnfill_cfg.sv
`timescale 1ns/1ps
module lnfill_cfg #(
   parameter int CODE_W   = 2,
   parameter int MAX_CODE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              busy,
   input  logic              release_i,
   output logic [CODE_W-1:0] code_o
);
   logic              legal_wr;
   logic              pend_v;
   logic [CODE_W-1:0] pend_c;
   logic [CODE_W-1:0] code_q;

   assign legal_wr = wr_en && (int'(wr_code) <= MAX_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         pend_v <= 1'b0;
         pend_c <= '0;
      end else if (release_i) begin
         if (legal_wr)    code_q <= wr_code;
         else if (pend_v) code_q <= pend_c;
         pend_v <= 1'b0;
      end else if (busy) begin
         if (legal_wr) begin
            pend_v <= 1'b1;
            pend_c <= wr_code;
         end
      end else if (legal_wr) begin
         code_q <= wr_code;
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/lnfill_agen.sv
`timescale 1ns/1ps
module lnfill_agen #(
   parameter int ADDR_W       = 32,
   parameter int BOFF_W       = 2,
   parameter int WSEL_W       = 2,
   parameter int LINE_IDX_W   = 6,
   parameter int MAX_GRP_LOG2 = 2,
   parameter int CODE_W       = 2,
   parameter int CNT_W        = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  step,
   input  logic [ADDR_W-1:0]     miss_addr,
   input  logic [CODE_W-1:0]     code,
   output logic [ADDR_W-1:0]     addr_o,
   output logic [LINE_IDX_W-1:0] cur_line_o,
   output logic [LINE_IDX_W-1:0] seal_line_o,
   output logic [WSEL_W-1:0]     wsel_o,
   output logic                  line_end_o,
   output logic                  all_done_o
);
   localparam int PLINE_OFF_W = BOFF_W + WSEL_W;
   localparam int WORD_BYTES  = 1 << BOFF_W;
   localparam int PL_WORDS    = 1 << WSEL_W;

   logic [ADDR_W-1:0]     aligned [MAX_GRP_LOG2+1];
   logic [ADDR_W-1:0]     base;
   logic [CNT_W-1:0]      total;
   logic [ADDR_W-1:0]     addr_q;
   logic [CNT_W-1:0]      rem_q;
   logic [LINE_IDX_W-1:0] seal_q;

   for (genvar g = 0; g <= MAX_GRP_LOG2; g++) begin : g_align
      localparam int LOW = PLINE_OFF_W + g;
      assign aligned[g] = {miss_addr[ADDR_W-1:LOW], {LOW{1'b0}}};
   end

   always_comb begin
      base = aligned[0];
      for (int g = 0; g <= MAX_GRP_LOG2; g++) begin
         if (code == CODE_W'(g)) base = aligned[g];
      end
   end

   assign total = CNT_W'(PL_WORDS) << code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
         seal_q <= '0;
      end else if (load) begin
         addr_q <= base;
         rem_q  <= total;
      end else if (step) begin
         addr_q <= addr_q + ADDR_W'(WORD_BYTES);
         rem_q  <= rem_q - CNT_W'(1);
         seal_q <= addr_q[PLINE_OFF_W +: LINE_IDX_W];
      end
   end

   assign addr_o      = addr_q;
   assign cur_line_o  = addr_q[PLINE_OFF_W +: LINE_IDX_W];
   assign seal_line_o = seal_q;
   assign wsel_o      = addr_q[BOFF_W +: WSEL_W];
   assign line_end_o  = (addr_q[BOFF_W +: WSEL_W] == {WSEL_W{1'b1}});
   assign all_done_o  = (rem_q == '0);
endmodule

// File: rtl/lnfill_fsm.sv
`timescale 1ns/1ps
module lnfill_fsm
   import lnfill_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic miss_valid,
   input  logic rsp_valid,
   input  logic line_end,
   input  logic all_done,
   output logic start,
   output logic step,
   output logic fetching,
   output logic sealing,
   output logic busy,
   output logic done
);
   lf_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LF_IDLE:  if (miss_valid) st_d = LF_FETCH;
         LF_FETCH: if (rsp_valid && line_end) st_d = LF_SEAL;
         LF_SEAL:  st_d = all_done ? LF_IDLE : LF_FETCH;
         default:  st_d = LF_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= LF_IDLE;
      else        st_q <= st_d;
   end

   assign start    = (st_q == LF_IDLE) && miss_valid;
   assign fetching = (st_q == LF_FETCH);
   assign step     = fetching && rsp_valid;
   assign sealing  = (st_q == LF_SEAL);
   assign busy     = (st_q != LF_IDLE);
   assign done     = sealing && all_done;
endmodule

// File: rtl/lnfill_ctrl.sv
`timescale 1ns/1ps
module lnfill_ctrl #(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter int WORDS_PER_LINE = 4,
   parameter int LINE_IDX_W     = 6,
   parameter int MAX_GRP_LOG2   = 2,
   localparam int CODE_W        = (MAX_GRP_LOG2 < 1) ? 1 : $clog2(MAX_GRP_LOG2 + 1),
   localparam int WSEL_W        = $clog2(WORDS_PER_LINE)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CODE_W-1:0]     cfg_code,
   output logic [CODE_W-1:0]     cfg_cur,
   input  logic                  miss_valid,
   input  logic [ADDR_W-1:0]     miss_addr,
   output logic                  stall,
   output logic                  done,
   output logic                  mem_req,
   output logic [ADDR_W-1:0]     mem_addr,
   input  logic                  mem_rsp_valid,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  arr_we,
   output logic                  arr_vld_set,
   output logic [LINE_IDX_W-1:0] arr_line,
   output logic [WSEL_W-1:0]     arr_word_sel,
   output logic [DATA_W-1:0]     arr_wdata
);
   localparam int BOFF_W = $clog2(DATA_W / 8);
   localparam int CNT_W  = WSEL_W + MAX_GRP_LOG2 + 1;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("lnfill_ctrl: DATA_W must be a power of two of at least 8");
   end
   if (WORDS_PER_LINE < 2 || (WORDS_PER_LINE & (WORDS_PER_LINE - 1)) != 0) begin : g_bad_words
      $error("lnfill_ctrl: WORDS_PER_LINE must be a power of two of at least 2");
   end
   if (ADDR_W < BOFF_W + WSEL_W + LINE_IDX_W + MAX_GRP_LOG2) begin : g_bad_addr
      $error("lnfill_ctrl: ADDR_W too narrow for the line index and largest block");
   end

   logic start, step, fetching, sealing, busy, done_i;
   logic line_end, all_done;
   logic [ADDR_W-1:0]     cur_addr;
   logic [LINE_IDX_W-1:0] cur_line, seal_line;
   logic [WSEL_W-1:0]     wsel;
   logic [CODE_W-1:0]     code;

   lnfill_cfg #(
      .CODE_W   (CODE_W),
      .MAX_CODE (MAX_GRP_LOG2)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_code   (cfg_code),
      .busy      (busy),
      .release_i (done_i),
      .code_o    (code)
   );

   lnfill_agen #(
      .ADDR_W       (ADDR_W),
      .BOFF_W       (BOFF_W),
      .WSEL_W       (WSEL_W),
      .LINE_IDX_W   (LINE_IDX_W),
      .MAX_GRP_LOG2 (MAX_GRP_LOG2),
      .CODE_W       (CODE_W),
      .CNT_W        (CNT_W)
   ) u_agen (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (start),
      .step        (step),
      .miss_addr   (miss_addr),
      .code        (code),
      .addr_o      (cur_addr),
      .cur_line_o  (cur_line),
      .seal_line_o (seal_line),
      .wsel_o      (wsel),
      .line_end_o  (line_end),
      .all_done_o  (all_done)
   );

   lnfill_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .rsp_valid  (mem_rsp_valid),
      .line_end   (line_end),
      .all_done   (all_done),
      .start      (start),
      .step       (step),
      .fetching   (fetching),
      .sealing    (sealing),
      .busy       (busy),
      .done       (done_i)
   );

   assign cfg_cur      = code;
   assign stall        = busy && !done_i;
   assign done         = done_i;
   assign mem_req      = fetching;
   assign mem_addr     = cur_addr;
   assign arr_we       = step;
   assign arr_vld_set  = sealing;
   assign arr_line     = sealing ? seal_line : cur_line;
   assign arr_word_sel = wsel;
   assign arr_wdata    = mem_rdata;
endmodule

// File: rtl/lnfill_chk.sv
`timescale 1ns/1ps
module lnfill_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_IDX_W = 6,
   parameter int WSEL_W     = 2,
   parameter int CODE_W     = 2,
   parameter int MAX_CODE   = 2,
   parameter int BOFF_W     = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [CODE_W-1:0]     cfg_cur,
   input logic                  stall,
   input logic                  done,
   input logic                  mem_req,
   input logic [ADDR_W-1:0]     mem_addr,
   input logic                  mem_rsp_valid,
   input logic                  arr_we,
   input logic                  arr_vld_set,
   input logic [LINE_IDX_W-1:0] arr_line,
   input logic [WSEL_W-1:0]     arr_word_sel
);
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cfg_cur) <= MAX_CODE); // R2
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[BOFF_W-1:0] == '0)); // R3
   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && arr_word_sel != {WSEL_W{1'b1}}) |=>
         (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1 << BOFF_W))); // R3
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr))); // R4
   AST_SEAL_AFTER_WORD3: assert property (@(posedge clk) disable iff (!rst_n)
      arr_vld_set |-> ($past(arr_we) && $past(arr_word_sel) == {WSEL_W{1'b1}}
                       && $past(arr_line) == arr_line)); // R6
   AST_GAP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      arr_vld_set |-> !mem_req); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!stall && arr_vld_set)); // R8
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(cfg_cur)); // R10
endmodule

bind lnfill_ctrl lnfill_chk #(
   .ADDR_W     (ADDR_W),
   .LINE_IDX_W (LINE_IDX_W),
   .WSEL_W     (WSEL_W),
   .CODE_W     (CODE_W),
   .MAX_CODE   (MAX_GRP_LOG2),
   .BOFF_W     ($clog2(DATA_W / 8))
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_cur       (cfg_cur),
   .stall         (stall),
   .done          (done),
   .mem_req       (mem_req),
   .mem_addr      (mem_addr),
   .mem_rsp_valid (mem_rsp_valid),
   .arr_we        (arr_we),
   .arr_vld_set   (arr_vld_set),
   .arr_line      (arr_line),
   .arr_word_sel  (arr_word_sel)
);

// File: tb/tb_lnfill_ctrl.sv
`timescale 1ns/1ps
module tb_lnfill_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_code = 2'd0;
   logic [1:0]  cfg_cur;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_addr = '0;
   logic        stall, done, mem_req;
   logic [31:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        arr_we, arr_vld_set;
   logic [5:0]  arr_line;
   logic [1:0]  arr_word_sel;
   logic [31:0] arr_wdata;

   always #10 clk = ~clk;

   lnfill_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_cur(cfg_cur),
      .miss_valid(miss_valid), .miss_addr(miss_addr), .stall(stall), .done(done),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rdata(mem_rdata), .arr_we(arr_we), .arr_vld_set(arr_vld_set),
      .arr_line(arr_line), .arr_word_sel(arr_word_sel), .arr_wdata(arr_wdata)
   );

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return a ^ 32'h5A5A_C3C3;
   endfunction

   // requests from the stimulus thread, consumed at the next falling edge
   bit          rq_miss = 0;
   logic [31:0] rq_addr = '0;
   bit          rq_cfg = 0;
   logic [1:0]  rq_code = '0;
   int          lat = 0;
   int          lat_cnt = 0;
   bit          run = 0;

   // reference model
   int          m_state = 0;       // 0 idle, 1 fetching, 2 sealing a line
   logic [31:0] m_q[$];
   logic [1:0]  m_cfg = 0;
   logic [1:0]  m_rcode = 0;
   bit          m_pv = 0;
   logic [1:0]  m_pc = 0;
   logic [5:0]  m_seal = 0;
   int          wr_cnt = 0;
   int          gap_cnt = 0;

   always @(negedge clk) begin
      if (run) begin
         // drive inputs for the coming rising edge
         miss_valid = rq_miss;  miss_addr = rq_addr;  rq_miss = 0;
         cfg_we     = rq_cfg;   cfg_code  = rq_code;  rq_cfg  = 0;
         if (mem_req && lat_cnt >= lat) begin
            mem_rsp_valid = 1'b1;
            mem_rdata     = mem_word(mem_addr);
            lat_cnt       = 0;
         end else begin
            mem_rsp_valid = 1'b0;
            mem_rdata     = 32'hDEAD_BEEF;
            if (mem_req) lat_cnt++;
         end
         #1;
         begin : compare
            bit          fin;
            logic [31:0] ea;
            fin = (m_state == 2) && (m_q.size() == 0);
            ea  = (m_q.size() != 0) ? m_q[0] : 32'h0;
            chk(stall == ((m_state != 0) && !fin), "R8", "stall", 32'(stall), 32'((m_state != 0) && !fin));
            chk(done == fin, "R8", "done", 32'(done), 32'(fin));
            chk(mem_req == (m_state == 1), "R7", "mem_req", 32'(mem_req), 32'(m_state == 1));
            if (m_state == 1)
               chk(mem_addr == ea, "R3", "mem_addr", mem_addr, ea);
            chk(arr_we == ((m_state == 1) && mem_rsp_valid), "R5", "arr_we", 32'(arr_we),
                32'((m_state == 1) && mem_rsp_valid));
            if (m_state == 1 && mem_rsp_valid) begin
               chk(arr_line == ea[9:4], "R5", "arr_line", 32'(arr_line), 32'(ea[9:4]));
               chk(arr_word_sel == ea[3:2], "R5", "arr_word_sel", 32'(arr_word_sel), 32'(ea[3:2]));
               chk(arr_wdata == mem_word(ea), "R5", "arr_wdata", arr_wdata, mem_word(ea));
            end
            chk(arr_vld_set == (m_state == 2), "R6", "arr_vld_set", 32'(arr_vld_set), 32'(m_state == 2));
            if (m_state == 2)
               chk(arr_line == m_seal, "R6", "sealed line", 32'(arr_line), 32'(m_seal));
            chk(cfg_cur == m_cfg, "R10", "cfg_cur", 32'(cfg_cur), 32'(m_cfg));
            // observed counts per refill
            if (arr_we) wr_cnt++;
            if (stall && !mem_req) gap_cnt++;
            if (done) begin
               chk(wr_cnt == (4 << m_rcode), "R3", "words per refill", 32'(wr_cnt), 32'(4 << m_rcode));
               chk(gap_cnt == ((1 << m_rcode) - 1), "R7", "gap cycles", 32'(gap_cnt),
                   32'((1 << m_rcode) - 1));
               wr_cnt = 0;
               gap_cnt = 0;
            end
         end
         // advance the model across the rising edge
         begin : advance
            bit ok;
            ok = cfg_we && (cfg_code != 2'd3);
            case (m_state)
               0: begin
                  if (miss_valid) begin
                     logic [31:0] base;
                     base = miss_addr & ~((32'd16 << m_cfg) - 32'd1);
                     for (int i = 0; i < (4 << m_cfg); i++) m_q.push_back(base + 32'(4 * i));
                     m_rcode = m_cfg;
                     m_state = 1;
                  end
                  if (ok) m_cfg = cfg_code;
               end
               1: begin
                  if (mem_rsp_valid) begin
                     logic [31:0] a;
                     a = m_q.pop_front();
                     if (a[3:2] == 2'd3) begin
                        m_seal  = a[9:4];
                        m_state = 2;
                     end
                  end
                  if (ok) begin m_pv = 1; m_pc = cfg_code; end
               end
               default: begin
                  if (m_q.size() == 0) begin
                     m_state = 0;
                     if (ok)        m_cfg = cfg_code;
                     else if (m_pv) m_cfg = m_pc;
                     m_pv = 0;
                  end else begin
                     m_state = 1;
                     if (ok) begin m_pv = 1; m_pc = cfg_code; end
                  end
               end
            endcase
         end
      end
   end

   task automatic slot();
      @(posedge clk);
      #2;
   endtask

   task automatic do_miss(input logic [31:0] a);
      slot();
      rq_miss = 1;
      rq_addr = a;
   endtask

   task automatic do_cfg(input logic [1:0] c);
      slot();
      rq_cfg  = 1;
      rq_code = c;
   endtask

   task automatic wait_idle();
      slot();
      slot();
      while (m_state != 0) slot();
      repeat (3) slot();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #2;
      // R1: state held in reset
      chk(!stall && !done && !mem_req && !arr_we && !arr_vld_set, "R1", "idle outputs in reset",
          {27'd0, stall, done, mem_req, arr_we, arr_vld_set}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk(cfg_cur == 2'd0, "R1", "cfg_cur after reset", 32'(cfg_cur), 32'd0);
      chk(!stall && !mem_req, "R1", "idle after reset", {30'd0, stall, mem_req}, 32'd0);
      run = 1;

      // R3: 16-byte refill, zero latency, no gap cycle (R7)
      lat = 0;
      do_miss(32'h0000_1234);
      wait_idle();

      // R2: 32-byte line, latency 1
      do_cfg(2'd1);
      slot();
      chk(cfg_cur == 2'd1, "R2", "code 1 accepted", 32'(cfg_cur), 32'd1);
      lat = 1;
      do_miss(32'h0000_5678);
      wait_idle();

      // R3: 64-byte line, miss on physical line 2 of its group starts at line 0
      do_cfg(2'd2);
      lat = 2;
      do_miss(32'h0000_00A8);
      wait_idle();

      // R2: illegal code ignored
      do_cfg(2'd3);
      slot();
      slot();
      chk(cfg_cur == 2'd2, "R2", "code 3 ignored", 32'(cfg_cur), 32'd2);

      // R9 and R10: writes and a miss during a refill
      lat = 0;
      do_miss(32'h0001_0FF0);
      slot();
      slot();
      do_cfg(2'd0);
      do_miss(32'h0000_4444);
      slot();
      chk(cfg_cur == 2'd2, "R10", "held during refill", 32'(cfg_cur), 32'd2);
      do_cfg(2'd1);
      wait_idle();
      chk(cfg_cur == 2'd1, "R10", "last held write applied", 32'(cfg_cur), 32'd1);
      chk(!stall && !mem_req, "R9", "miss during refill not serviced",
          {30'd0, stall, mem_req}, 32'd0);

      // R11: miss and size write in the same idle cycle
      slot();
      rq_miss = 1;
      rq_addr = 32'h0002_003C;
      rq_cfg  = 1;
      rq_code = 2'd0;
      wait_idle();
      chk(cfg_cur == 2'd0, "R11", "write applied after miss", 32'(cfg_cur), 32'd0);

      // top of the address space, 16-byte line, latency 2
      lat = 2;
      do_miss(32'hFFFF_FFFC);
      wait_idle();

      // 64-byte line, back-to-back misses
      do_cfg(2'd2);
      lat = 1;
      do_miss(32'h0000_03F0);
      wait_idle();
      do_miss(32'h0000_0414);
      wait_idle();

      run = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule